// File: doc/BRIEF.md
# Latency-Hiding Warp Scheduler

This block tracks every warp slot resident on one multiprocessor and, each cycle, names at most one ready warp to issue. A group of threads asks for slots with a thread count. The count is rounded up to whole 32-thread warps, and the request is granted only if enough slots are free. When the issued warp begins a long-latency operation, it raises a stall in the same cycle. The warp then leaves the ready set and is skipped until a wake-up event that carries its ID returns it. A finished warp is retired and its slot becomes free in the next cycle.

Each slot is a three-state machine. The states are FREE, READY and WAIT. The transitions are:
- ALLOC: FREE to READY.
- STALL: READY to WAIT.
- WAKE: WAIT to READY.
- RETIRE: READY or WAIT to FREE.

Among the READY slots, a round-robin arbiter starts its search just after the warp issued last. When nothing is ready, the issue valid output stays low. A wake-up for a slot that is not in WAIT does nothing and raises a one-cycle protocol error flag.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset every slot is FREE, `issue_valid` is 0 and `wake_err` is 0.
- R2: A request for T threads needs ceil(T/32) slots. It is granted in the same cycle (`alloc_grant`=1) when T>0 and that many slots are FREE. The granted slots are the lowest-numbered FREE slots, and they become READY in the next cycle.
- R3: A request is refused (`alloc_grant`=0) when T=0 or when fewer than ceil(T/32) slots are FREE. A refused request changes no slot.
- R4: At most one warp is issued per cycle. When `issue_valid`=1, `issue_id` is a READY slot. `issue_valid` is 0 exactly in the cycles when no slot is READY.
- R5: The issued warp is the first READY slot found after the last issued ID, counting upward and wrapping from NUM_WARPS-1 to 0. After reset the search starts at slot 0.
- R6: `stall` together with `issue_valid` moves the issued warp to WAIT from the next cycle. A waiting warp is never issued.
- R7: `wake_valid` with the ID of a WAIT slot makes that slot READY in the next cycle.
- R8: A wake-up is ignored when its ID is not a WAIT slot, including IDs at or above NUM_WARPS. In that case `wake_err` is 1 in the following cycle.
- R9: `retire_valid` turns a READY or WAIT slot into FREE in the next cycle. The freed slot is not counted as free for a grant in the retire cycle. Retire takes priority over stall and wake for the same slot.
- R10: NUM_WARPS sets the resident limit, with 24 as the default and 32 as the option. With 32, a request for 1024 threads is granted from empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_req | input | 1 | Slot allocation request |
| alloc_threads | input | CNT_W | Thread count of the request |
| alloc_grant | output | 1 | Request accepted this cycle |
| stall | input | 1 | Issued warp starts a long-latency operation |
| wake_valid | input | 1 | Long-latency result returned |
| wake_id | input | ID_W | Warp the result belongs to |
| retire_valid | input | 1 | Warp finished |
| retire_id | input | ID_W | Warp being retired |
| issue_valid | output | 1 | A warp is issued this cycle |
| issue_id | output | ID_W | Issued warp |
| wake_err | output | 1 | Previous-cycle wake-up hit a non-waiting warp |

## Verification
The bench targets the points where a scheduler usually slips.

- A design that counts a retiring slot as free in the same cycle would grant a full request one cycle early.
- A request one warp over capacity, and a request for zero threads, must both be refused. A design that truncates T/32 instead of rounding up would grant a request it cannot hold.
- When the only ready warp stalls, `issue_valid` must drop. A design that left the stalled warp in the candidate set would keep issuing it.
- A repeated wake-up and an out-of-range ID must raise the error without reviving anything.
- Under random traffic, any ordering fault in the round-robin pointer shows up as a wrong `issue_id` against the reference model.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
    localparam int WARP_THREADS = 32;
    localparam int WARP_SHIFT   = $clog2(WARP_THREADS);

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_READY = 2'd1,
        SLOT_WAIT  = 2'd2
    } slot_state_e;
endpackage

// File: rtl/wsched_slot.sv
module wsched_slot
    import wsched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic stall_hit,
    input  logic wake_hit,
    input  logic retire_hit,
    output logic is_free,
    output logic is_ready,
    output logic is_wait
);
    slot_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    // transitions: ALLOC, STALL, WAKE, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE:  if (take) state_d = SLOT_READY;
            SLOT_READY: begin
                if (retire_hit)     state_d = SLOT_FREE;
                else if (stall_hit) state_d = SLOT_WAIT;
            end
            SLOT_WAIT: begin
                if (retire_hit)    state_d = SLOT_FREE;
                else if (wake_hit) state_d = SLOT_READY;
            end
            default: state_d = SLOT_FREE;
        endcase
    end

    // outputs
    always_comb begin
        is_free  = 1'b0;
        is_ready = 1'b0;
        is_wait  = 1'b0;
        unique case (state_q)
            SLOT_FREE:  is_free  = 1'b1;
            SLOT_READY: is_ready = 1'b1;
            SLOT_WAIT:  is_wait  = 1'b1;
            default:    is_free  = 1'b1;
        endcase
    end

    // R6: a waiting warp stays waiting until woken or retired
    p_wait_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wait && !wake_hit && !retire_hit) |=> is_wait);

    // R9: retire frees a resident slot on the next cycle
    p_retire_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_hit && !is_free) |=> is_free);
endmodule

// File: rtl/wsched_alloc.sv
module wsched_alloc
    import wsched_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    parameter int CNT_W     = 10
) (
    input  logic                 req,
    input  logic [CNT_W-1:0]     threads,
    input  logic [NUM_WARPS-1:0] free_mask,
    output logic                 grant,
    output logic [NUM_WARPS-1:0] take_mask
);
    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] need;
    logic [SUM_W-1:0] free_cnt;
    logic [SUM_W-1:0] seen;

    always_comb begin
        need = ({1'b0, threads} + SUM_W'(WARP_THREADS - 1)) >> WARP_SHIFT;
        free_cnt = '0;
        for (int i = 0; i < NUM_WARPS; i++) begin
            if (free_mask[i]) free_cnt = free_cnt + SUM_W'(1);
        end
        grant = req && (need != '0) && (need <= free_cnt);
        seen = '0;
        take_mask = '0;
        for (int i = 0; i < NUM_WARPS; i++) begin
            if (free_mask[i]) begin
                take_mask[i] = grant && (seen < need);
                seen = seen + SUM_W'(1);
            end
        end
    end
endmodule

// File: rtl/wsched_rr.sv
module wsched_rr #(
    parameter int NUM_WARPS = 24,
    parameter int ID_W      = 5
) (
    input  logic [NUM_WARPS-1:0] ready_mask,
    input  logic [ID_W-1:0]      last_id,
    output logic                 valid,
    output logic [ID_W-1:0]      pick_id
);
    int idx;

    always_comb begin
        valid   = 1'b0;
        pick_id = '0;
        idx     = 0;
        for (int k = 1; k <= NUM_WARPS; k++) begin
            idx = int'(last_id) + k;
            if (idx >= NUM_WARPS) idx = idx - NUM_WARPS;
            if (!valid && ready_mask[idx]) begin
                valid   = 1'b1;
                pick_id = ID_W'(idx);
            end
        end
    end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import wsched_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    parameter int ID_W      = $clog2(NUM_WARPS),
    parameter int CNT_W     = $clog2(NUM_WARPS * 32 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic [CNT_W-1:0] alloc_threads,
    output logic             alloc_grant,
    input  logic             stall,
    input  logic             wake_valid,
    input  logic [ID_W-1:0]  wake_id,
    input  logic             retire_valid,
    input  logic [ID_W-1:0]  retire_id,
    output logic             issue_valid,
    output logic [ID_W-1:0]  issue_id,
    output logic             wake_err
);
    logic [NUM_WARPS-1:0] free_mask, ready_mask, wait_mask, take_mask;
    logic [NUM_WARPS-1:0] stall_hit, wake_hit, retire_hit;
    logic [ID_W-1:0]      last_q;
    logic                 wake_ok;

    wsched_alloc #(.NUM_WARPS(NUM_WARPS), .CNT_W(CNT_W)) u_alloc (
        .req(alloc_req), .threads(alloc_threads), .free_mask(free_mask),
        .grant(alloc_grant), .take_mask(take_mask)
    );

    wsched_rr #(.NUM_WARPS(NUM_WARPS), .ID_W(ID_W)) u_rr (
        .ready_mask(ready_mask), .last_id(last_q),
        .valid(issue_valid), .pick_id(issue_id)
    );

    always_comb begin
        wake_ok = 1'b0;
        for (int i = 0; i < NUM_WARPS; i++) begin
            stall_hit[i]  = stall && issue_valid && (issue_id == ID_W'(i));
            wake_hit[i]   = wake_valid && (wake_id == ID_W'(i));
            retire_hit[i] = retire_valid && (retire_id == ID_W'(i));
            if (wake_hit[i] && wait_mask[i]) wake_ok = 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_slot
        wsched_slot u_slot (
            .clk(clk), .rst_n(rst_n), .take(take_mask[g]),
            .stall_hit(stall_hit[g]), .wake_hit(wake_hit[g]),
            .retire_hit(retire_hit[g]),
            .is_free(free_mask[g]), .is_ready(ready_mask[g]),
            .is_wait(wait_mask[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q   <= ID_W'(NUM_WARPS - 1);
            wake_err <= 1'b0;
        end else begin
            if (issue_valid) last_q <= issue_id;
            wake_err <= wake_valid && !wake_ok;
        end
    end

    // R4: issued warp is one of the ready slots
    p_issue_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ready_mask[issue_id]);
    // R4: something ready means something issues
    p_no_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_mask != '0) |-> issue_valid);
    // R6: never pick a waiting warp
    p_no_wait_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !wait_mask[issue_id]);
    // R2: allocation only takes free slots
    p_take_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_mask & ~free_mask) == '0);
    // R2: a grant takes at least one slot
    p_grant_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |-> $countones(take_mask) != 0);
    // R8: bad wake-up flagged next cycle
    p_wake_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_valid && !wake_ok) |=> wake_err);
endmodule

// File: tb/sim_warp_issue_sched.sv
module sim_warp_issue_sched;
    localparam int NW = 24;
    localparam int IW = 5;
    localparam int CW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          a_req = 0, stall_i = 0, wk_v = 0, rt_v = 0;
    logic [CW-1:0] a_thr = '0;
    logic [IW-1:0] wk_id = '0, rt_id = '0;
    logic          grant, iv, werr;
    logic [IW-1:0] iid;

    warp_issue_sched u0 (
        .clk(clk), .rst_n(rst_n), .alloc_req(a_req), .alloc_threads(a_thr),
        .alloc_grant(grant), .stall(stall_i), .wake_valid(wk_v), .wake_id(wk_id),
        .retire_valid(rt_v), .retire_id(rt_id), .issue_valid(iv), .issue_id(iid),
        .wake_err(werr)
    );

    logic        b_req = 0;
    logic [10:0] b_thr = '0;
    logic        b_grant, b_iv, b_err;
    logic [4:0]  b_iid;

    warp_issue_sched #(.NUM_WARPS(32)) u1 (
        .clk(clk), .rst_n(rst_n), .alloc_req(b_req), .alloc_threads(b_thr),
        .alloc_grant(b_grant), .stall(1'b0), .wake_valid(1'b0), .wake_id(5'd0),
        .retire_valid(1'b0), .retire_id(5'd0), .issue_valid(b_iv), .issue_id(b_iid),
        .wake_err(b_err)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model: 0 free, 1 ready, 2 waiting
    int st[NW];
    int last = NW - 1;
    bit err_q = 0;
    bit e_grant, e_iv;
    int e_iid;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_eval();
        int need, freec;
        need  = (int'(a_thr) + 31) / 32;
        freec = 0;
        foreach (st[i]) if (st[i] == 0) freec++;
        e_grant = a_req && need > 0 && need <= freec;
        e_iv = 0;
        e_iid = 0;
        for (int k = 1; k <= NW; k++) begin
            int w;
            w = (last + k) % NW;
            if (!e_iv && st[w] == 1) begin
                e_iv = 1;
                e_iid = w;
            end
        end
    endtask

    task automatic model_update();
        int nst[NW];
        int need, taken;
        need  = (int'(a_thr) + 31) / 32;
        taken = 0;
        for (int i = 0; i < NW; i++) begin
            bit rh, wh, sh;
            rh = rt_v && int'(rt_id) == i;
            wh = wk_v && int'(wk_id) == i;
            sh = stall_i && e_iv && e_iid == i;
            nst[i] = st[i];
            if (st[i] == 0) begin
                if (e_grant && taken < need) begin
                    nst[i] = 1;
                    taken++;
                end
            end else if (rh) nst[i] = 0;
            else if (st[i] == 1 && sh) nst[i] = 2;
            else if (st[i] == 2 && wh) nst[i] = 1;
        end
        err_q = wk_v && !(int'(wk_id) < NW && st[int'(wk_id)] == 2);
        if (e_iv) last = e_iid;
        st = nst;
    endtask

    // called at a negedge with inputs applied; returns at the next negedge
    task automatic step();
        #1;
        model_eval();
        check(e_grant ? "R2" : "R3", int'(grant), int'(e_grant));
        check("R4", int'(iv), int'(e_iv));
        if (e_iv) check("R5", int'(iid), e_iid);
        check("R8", int'(werr), int'(err_q));
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle();
        a_req = 0; a_thr = '0; stall_i = 0; wk_v = 0; rt_v = 0;
    endtask

    initial begin
        foreach (st[i]) st[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", int'(iv), 0);
        check("R1", int'(werr), 0);
        #1;
        // two warps, round robin 0,1,0
        a_req = 1; a_thr = 10'd64; step(); idle();
        repeat (3) step();
        // stall whichever is issued until none ready
        stall_i = 1; step(); step(); idle();
        #1; check("R6", int'(iv), 0); #1;
        step();
        wk_v = 1; wk_id = 5'd0; step(); idle();
        #1; check("R7", int'(iv), 1); check("R7", int'(iid), 0); #1;
        wk_v = 1; wk_id = 5'd0; step();  // not waiting: error
        wk_id = 5'd30; step(); idle();  // out of range: error
        #1; check("R8", int'(werr), 1); #1;
        step();
        // over capacity and zero-size requests
        a_req = 1; a_thr = 10'd800; step();
        a_thr = 10'd0; step();
        a_thr = 10'd704; step();        // 22 warps, fills all
        a_thr = 10'd1; step();          // refused, full
        // retire and allocate in the same cycle: still refused
        rt_v = 1; rt_id = 5'd5; a_thr = 10'd32;
        #1; check("R9", int'(grant), 0); #1;
        step(); rt_v = 0;
        #1; check("R9", int'(grant), 1); #1;
        step(); idle();
        // random traffic
        for (int n = 0; n < 3000; n++) begin
            a_req   = ($urandom_range(0, 3) == 0);
            a_thr   = CW'($urandom_range(0, 400));
            stall_i = ($urandom_range(0, 2) == 0);
            wk_v    = ($urandom_range(0, 1) == 0);
            wk_id   = IW'($urandom_range(0, 31));
            rt_v    = ($urandom_range(0, 5) == 0);
            rt_id   = IW'($urandom_range(0, NW - 1));
            step();
        end
        idle();
        // 32-warp option
        b_req = 1; b_thr = 11'd1024;
        #1; check("R10", int'(b_grant), 1); #1;
        @(negedge clk); b_req = 0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule